// File: doc/BRIEF.md
# Program Verify Read Port with Encryption Masking

This block is the device-side read path used while a programmer inspects on-chip code memory. Static control pins choose among four operations: read back a code byte, read a fixed identification byte, write a code byte, or write an encryption byte. A code byte read back leaves the block masked with one of 64 encryption bytes. The mask is the bitwise XNOR of the code byte and the encryption byte picked by the six least significant address bits. Both arrays start erased, with every bit at one. In that state the XNOR returns the stored code unchanged, and an erased code byte shows the encryption byte for its index.

Programming happens on a falling edge of the active-low program strobe while the programming voltage is present. Each write ANDs the new byte into the addressed cell, because a programmed bit can only return to one through an erase, modelled here as reset. A lock input from the protection logic can forbid code read-back. The byte lane is tri-state, represented as `data_o` together with an enable `data_oe_o`. Outputs are registered and appear one clock after the pins are sampled.

Top module: `vp_read_port`

## Requirements
- R1: While `rst_ni` is low and at the first edge after it rises, `data_oe_o` is 0 and `data_o` is 8'hFF, and every code and encryption cell holds 8'hFF.
- R2: Read-back mode is decoded when `rst_pin_i`=1, `psen_ni`=0, `prog_ni`=1, `ea_i`=1, `vpp_i`=0 and `sel_i`=5'b00011. Signature mode uses the same pins with `sel_i`=5'b00000. Outputs are registered: the response to pins sampled at one rising edge is visible after that edge.
- R3: In read-back mode `data_o` = ~(code[addr_i[CODE_AW-1:0]] ^ enc[addr_i[5:0]]) and `data_oe_o` = 1. Address bits at and above CODE_AW do not affect the code index.
- R4: With an erased encryption byte, read-back returns the code byte unchanged. With an erased code byte, read-back returns the encryption byte for that index.
- R5: In signature mode, address 14'h030 gives 8'h89, 14'h031 gives 8'h58, 14'h060 gives SIG_DEV (default 8'h12), and any other address gives 8'hFF. `data_oe_o` = 1, and `verify_lock_i` has no effect.
- R6: In read-back mode with `verify_lock_i`=1, `data_o` is 8'hFF and `data_oe_o` stays 1.
- R7: With any other pin combination, including read-back pins with `vpp_i`=1 or `prog_ni`=0, `data_oe_o` is 0 and `data_o` is 8'hFF.
- R8: With `rst_pin_i`=1, `psen_ni`=0 and `vpp_i`=1, a `prog_ni` high-to-low transition seen between two successive edges writes one cell. With `sel_i`=5'b01111 the cell is code[addr_i[CODE_AW-1:0]]. With `sel_i`=5'b01101 the cell is enc[addr_i[5:0]]. The write ANDs `data_i` into the cell, so no bit ever goes from 0 to 1. A read in the same cycle sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (erase) |
| rst_pin_i | input | 1 | Device reset pin, high in all programming/verify modes |
| psen_ni | input | 1 | Program store enable pin, low in all modes |
| prog_ni | input | 1 | Active-low program strobe |
| ea_i | input | 1 | External-access pin at logic high |
| vpp_i | input | 1 | Programming voltage present |
| sel_i | input | 5 | Mode select pin group |
| verify_lock_i | input | 1 | Read-back forbidden by lock level |
| addr_i | input | 14 | Code address |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Read byte |
| data_oe_o | output | 1 | Byte lane drive enable |

## Verification
Two functions meet on a single clock edge: a program strobe updates a cell, and the registered read path samples that same array. The bench provokes this by firing an encryption write and switching the pins to read-back of the same index on the very next cycle. It also issues strobes while the read register is still presenting a byte from a previous read. A reference model that reads before it writes judges each cycle, so a stale or early value fails. Lock and mode changes are also applied in the same cycle as address changes, and the output is compared on every clock.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef enum logic [2:0] {
    MD_IDLE,
    MD_VERIFY,
    MD_SIG,
    MD_PGM_CODE,
    MD_PGM_ENC
  } vp_mode_e;

  localparam logic [4:0] SEL_VERIFY   = 5'b00011;
  localparam logic [4:0] SEL_SIG      = 5'b00000;
  localparam logic [4:0] SEL_PGM_CODE = 5'b01111;
  localparam logic [4:0] SEL_PGM_ENC  = 5'b01101;
endpackage

// File: rtl/vp_mode_dec.sv
module vp_mode_dec
  import vp_pkg::*;
(
  input  logic       rst_pin_i,
  input  logic       psen_ni,
  input  logic       prog_ni,
  input  logic       ea_i,
  input  logic       vpp_i,
  input  logic [4:0] sel_i,
  output vp_mode_e   mode_o
);
  logic base;
  assign base = rst_pin_i && !psen_ni;

  always_comb begin
    mode_o = MD_IDLE;
    if (base && vpp_i) begin
      if (sel_i == SEL_PGM_CODE)     mode_o = MD_PGM_CODE;
      else if (sel_i == SEL_PGM_ENC) mode_o = MD_PGM_ENC;
    end else if (base && ea_i && prog_ni) begin
      if (sel_i == SEL_VERIFY)       mode_o = MD_VERIFY;
      else if (sel_i == SEL_SIG)     mode_o = MD_SIG;
    end
  end
endmodule

// File: rtl/vp_and_mem.sv
module vp_and_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // erase = all ones; programming only clears bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  a_r8_no_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(waddr_i)] & ~$past(mem_q[waddr_i])) == '0))
    else $error("R8: programmed cell gained a one");

  a_r8_data_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(waddr_i)] & ~$past(wdata_i)) == '0))
    else $error("R8: zero bit of write data not cleared");
endmodule

// File: rtl/vp_read_port.sv
module vp_read_port
  import vp_pkg::*;
#(
  parameter int          ADDR_W  = 14,
  parameter int          CODE_AW = 10,
  parameter int          ENC_AW  = 6,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  SIG_DEV = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              psen_ni,
  input  logic              prog_ni,
  input  logic              ea_i,
  input  logic              vpp_i,
  input  logic [4:0]        sel_i,
  input  logic              verify_lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'('h31);
  localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'('h60);
  localparam logic [DATA_W-1:0] SIG_B0 = DATA_W'(8'h89);
  localparam logic [DATA_W-1:0] SIG_B1 = DATA_W'(8'h58);
  localparam logic [DATA_W-1:0] SIG_B2 = DATA_W'(SIG_DEV);

  vp_mode_e mode;
  logic prog_q, strobe, code_we, enc_we;
  logic [DATA_W-1:0] code_rd, enc_rd, rd_d, sig_d;
  logic oe_d;

  vp_mode_dec u_dec (
    .rst_pin_i(rst_pin_i), .psen_ni(psen_ni), .prog_ni(prog_ni),
    .ea_i(ea_i), .vpp_i(vpp_i), .sel_i(sel_i), .mode_o(mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b1;
    else         prog_q <= prog_ni;
  end

  assign strobe  = prog_q && !prog_ni;
  assign code_we = strobe && (mode == MD_PGM_CODE);
  assign enc_we  = strobe && (mode == MD_PGM_ENC);

  vp_and_mem #(.AW(CODE_AW), .DW(DATA_W)) u_code (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(code_we),
    .waddr_i(addr_i[CODE_AW-1:0]), .wdata_i(data_i),
    .raddr_i(addr_i[CODE_AW-1:0]), .rdata_o(code_rd)
  );

  vp_and_mem #(.AW(ENC_AW), .DW(DATA_W)) u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(enc_we),
    .waddr_i(addr_i[ENC_AW-1:0]), .wdata_i(data_i),
    .raddr_i(addr_i[ENC_AW-1:0]), .rdata_o(enc_rd)
  );

  always_comb begin
    unique case (addr_i)
      SIG_A0:  sig_d = SIG_B0;
      SIG_A1:  sig_d = SIG_B1;
      SIG_A2:  sig_d = SIG_B2;
      default: sig_d = '1;
    endcase
  end

  always_comb begin
    oe_d = 1'b0;
    rd_d = '1;
    if (mode == MD_VERIFY) begin
      oe_d = 1'b1;
      if (!verify_lock_i) rd_d = ~(code_rd ^ enc_rd);
    end else if (mode == MD_SIG) begin
      oe_d = 1'b1;
      rd_d = sig_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '1;
      data_oe_o <= 1'b0;
    end else begin
      data_o    <= rd_d;
      data_oe_o <= oe_d;
    end
  end

  a_r6_lock_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_VERIFY && verify_lock_i) |=> (data_oe_o && data_o == '1))
    else $error("R6: locked read-back not all ones");

  a_r7_idle_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '1)
    else $error("R7: undriven lane not all ones");

  a_r7_no_drive_in_pgm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_PGM_CODE || mode == MD_PGM_ENC) |=> !data_oe_o)
    else $error("R7: lane driven while programming");

  a_r5_sig_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_SIG && addr_i == SIG_A0) |=> (data_oe_o && data_o == SIG_B0))
    else $error("R5: wrong first signature byte");

  a_r3_read_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_VERIFY && !verify_lock_i) |=> data_o == $past(~(code_rd ^ enc_rd)))
    else $error("R3: read-back mismatch");
endmodule

// File: tb/vp_read_port_tb.sv
`timescale 1ns/1ps
module vp_read_port_tb;
  localparam int CODE_N = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin = 1'b1, psen_n = 1'b0, prog_n = 1'b1, ea = 1'b1, vpp = 1'b0;
  logic [4:0] sel = 5'b11111;
  logic lock = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vp_read_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(rst_pin), .psen_ni(psen_n),
    .prog_ni(prog_n), .ea_i(ea), .vpp_i(vpp), .sel_i(sel),
    .verify_lock_i(lock), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(oe)
  );

  // reference model
  byte unsigned code_m [CODE_N];
  byte unsigned enc_m [64];
  logic prog_prev;
  logic [7:0] exp_d;
  logic exp_oe;
  string exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (code_m[i]) code_m[i] = 8'hFF;
      foreach (enc_m[i]) enc_m[i] = 8'hFF;
      prog_prev = 1'b1;
      exp_d = 8'hFF; exp_oe = 1'b0; exp_tag = "R1";
    end else begin
      int ci, ei;
      bit rd_ok, pw;
      ci = int'(addr) % CODE_N;
      ei = int'(addr) % 64;
      rd_ok = rst_pin && !psen_n && ea && !vpp && prog_n;
      pw = rst_pin && !psen_n && vpp;
      exp_d = 8'hFF; exp_oe = 1'b0; exp_tag = "R7";
      if (rd_ok && sel == 5'b00011) begin
        exp_oe = 1'b1;
        if (lock) exp_tag = "R6";
        else begin exp_tag = "R3"; exp_d = ~(code_m[ci] ^ enc_m[ei]); end
      end else if (rd_ok && sel == 5'b00000) begin
        exp_oe = 1'b1; exp_tag = "R5";
        if (addr == 14'h030) exp_d = 8'h89;
        else if (addr == 14'h031) exp_d = 8'h58;
        else if (addr == 14'h060) exp_d = 8'h12;
      end
      if (prog_prev && !prog_n && pw) begin
        if (sel == 5'b01111) code_m[ci] = code_m[ci] & din;
        else if (sel == 5'b01101) enc_m[ei] = enc_m[ei] & din;
      end
      prog_prev = prog_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dout !== exp_d || oe !== exp_oe) begin
        errors++;
        $display("FAIL %s: data=%h oe=%b expected data=%h oe=%b", exp_tag, dout, oe, exp_d, exp_oe);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] d, logic e);
    checks++;
    if (dout !== d || oe !== e) begin
      errors++;
      $display("FAIL %s: data=%h oe=%b expected data=%h oe=%b", tag, dout, oe, d, e);
    end
  endtask

  task automatic pins_read(logic [4:0] s, logic [13:0] a);
    rst_pin = 1; psen_n = 0; ea = 1; vpp = 0; prog_n = 1; sel = s; addr = a;
  endtask

  task automatic pgm(logic [4:0] s, logic [13:0] a, logic [7:0] d);
    @(negedge clk); rst_pin = 1; psen_n = 0; vpp = 1; sel = s; addr = a; din = d; prog_n = 1;
    @(negedge clk); prog_n = 0;
    @(negedge clk); prog_n = 1;
  endtask

  task automatic read_and_check(string tag, logic [4:0] s, logic [13:0] a, logic [7:0] d, logic e);
    @(negedge clk); pins_read(s, a);
    @(negedge clk); chk(tag, d, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 8'hFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R1", 8'hFF, 1'b0);
    read_and_check("R1", 5'b00011, 14'h0123, 8'hFF, 1'b1);
    read_and_check("R2", 5'b00000, 14'h0031, 8'h58, 1'b1);
    read_and_check("R5", 5'b00000, 14'h0030, 8'h89, 1'b1);
    read_and_check("R5", 5'b00000, 14'h0060, 8'h12, 1'b1);
    read_and_check("R5", 5'b00000, 14'h0061, 8'hFF, 1'b1);
    pgm(5'b01111, 14'h0005, 8'h3C);
    read_and_check("R4", 5'b00011, 14'h0005, 8'h3C, 1'b1);
    pgm(5'b01101, 14'h0006, 8'hA5);
    // strobe then read-back of same index on next cycle
    @(negedge clk); pins_read(5'b00011, 14'h0046);
    @(negedge clk); chk("R4", 8'hA5, 1'b1);
    pgm(5'b01111, 14'h0006, 8'h0F);
    read_and_check("R3", 5'b00011, 14'h0006, 8'h55, 1'b1);
    read_and_check("R3", 5'b00011, 14'h0406, 8'h55, 1'b1);
    pgm(5'b01101, 14'h0006, 8'hFF);
    read_and_check("R8", 5'b00011, 14'h0046, 8'hA5, 1'b1);
    pgm(5'b01111, 14'h0005, 8'hF0);
    read_and_check("R8", 5'b00011, 14'h0005, 8'h30, 1'b1);
    @(negedge clk); lock = 1;
    read_and_check("R6", 5'b00011, 14'h0005, 8'hFF, 1'b1);
    read_and_check("R5", 5'b00000, 14'h0030, 8'h89, 1'b1);
    @(negedge clk); lock = 0;
    @(negedge clk); pins_read(5'b00011, 14'h0005); vpp = 1;
    @(negedge clk); chk("R7", 8'hFF, 1'b0);
    @(negedge clk); pins_read(5'b00011, 14'h0005); prog_n = 0;
    @(negedge clk); chk("R7", 8'hFF, 1'b0);
    read_and_check("R7", 5'b00111, 14'h0005, 8'hFF, 1'b0);
    // mixed traffic, judged by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      case ($urandom_range(0, 5))
        0: sel = 5'b00011;
        1: sel = 5'b00000;
        2: sel = 5'b01111;
        3: sel = 5'b01101;
        4: sel = 5'b00011;
        default: sel = 5'($urandom);
      endcase
      vpp = (sel == 5'b01111 || sel == 5'b01101) ? ($urandom_range(0, 7) != 0) : ($urandom_range(0, 15) == 0);
      prog_n = $urandom_range(0, 2) != 0;
      lock = $urandom_range(0, 7) == 0;
      ea = $urandom_range(0, 31) != 0;
      psen_n = $urandom_range(0, 31) == 0;
      addr = ($urandom_range(0, 3) == 0) ? 14'($urandom_range(14'h30, 14'h61)) : 14'($urandom);
      din = 8'($urandom);
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule